// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Write Sequencer

This block is a clocked model of the write side of a 2K x 8 byte-wide EEPROM. The three active-low control pins (chip enable, write enable, output enable) arrive asynchronously. They pass through a two-stage synchronizer, and a write strobe is the interval in which both enables are low while output enable is high. Either enable may be the one that opens or closes the strobe. The address is taken when the strobe opens, which is at the later of the two falling edges. The data is taken when the strobe closes, which is at the earlier of the two rising edges.

Accepted bytes collect in a 32-byte page buffer. An inactivity timer is restarted by every strobe. When it runs out, a fixed-length internal programming cycle starts, and at its end only the bytes that were loaded are written into the storage array. A busy flag and an open-drain pull-down enable report the write in progress. A registered read port, the load-window flag and the last accepted address and data are provided for the read and status path. After reset a power-up interval blocks all writes. All times are parameters counted in clock cycles.

Top module: `eep_page_writer`

## Requirements
- R1: After reset, busy, rb_pull and load_active are 0, and every storage location reads FFh.
- R2: A strobe exists only while ce_n=0, we_n=0 and oe_n=1. Enables held low while oe_n=0 load nothing and leave busy at 0.
- R3: The address is captured when the strobe opens (the later falling enable). Address changes while the strobe is open have no effect.
- R4: The data is captured when the strobe closes (the earlier rising enable). Data changes after that have no effect.
- R5: A page is 32 bytes. addr[10:5] is the page and addr[4:0] the byte within the page. The first byte of a load fixes the page, and later bytes of the same load that name a different page are discarded.
- R6: The load window stays open (load_active=1) until LOAD_WIN clock cycles pass with no strobe activity after the last strobe closes. Any strobe restarts the window. When the window runs out, programming starts.
- R7: Programming lasts PROG_CYC cycles and then writes the loaded bytes into the array. Locations of the page that were not loaded keep their old contents.
- R8: busy and rb_pull rise within a few cycles of the first strobe closing, and both stay 1 through the load window and programming.
- R9: A strobe that opens during programming is ignored. It writes nothing, and its byte is not taken into a later load.
- R10: If the same byte of a page is written twice in one load, the later data is the one stored.
- R11: For POWERUP_CYC cycles after reset, strobes are ignored and busy stays 0. Reads work during this time.
- R12: last_addr and last_data hold the address and data of the most recently accepted byte. Discarded strobes leave them unchanged.
- R13: rd_data shows the array content at rd_addr one clock after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | Load window open or programming in progress |
| rb_pull | output | 1 | Enable for the open-drain ready/busy pull-down |
| load_active | output | 1 | Byte-load window open |
| last_addr | output | ADDR_W | Address of the last accepted byte |
| last_data | output | DATA_W | Data of the last accepted byte |

## Verification
The hardest situations to reach are the ones where pin activity overlaps an internal phase boundary. Examples are a strobe that opens while programming is already running, a byte that names another page while a load is open, and a strobe placed so that address or data change after the capture point. The bench drives the pins in both enable orders. It moves the address between the two falling edges, and it moves the data after the first rising edge. It issues strobes at fixed offsets from the expected window expiry, so that each one lands inside the load window, inside programming, or inside the power-up interval. Random loads on a small set of pages then build up overlap between pages, so partial-page programming has to preserve earlier contents.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [1:0] {
        ST_INHIBIT,
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } pins_t;

    function automatic logic strobe_on(pins_t p);
        return !p.ce_n && !p.we_n && p.oe_n;
    endfunction

    function automatic int cnt_width(int a, int b, int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '1;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '1;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eep_strobe_det.sv
module eep_strobe_det
    import eep_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  pins_t         pins,
    input  logic          arm,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          active,
    output logic          byte_evt,
    output logic [AW-1:0] byte_addr,
    output logic [DW-1:0] byte_data
);
    logic act_q;
    logic armed_q;

    assign active = strobe_on(pins);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            armed_q   <= 1'b0;
            byte_evt  <= 1'b0;
            byte_addr <= '0;
            byte_data <= '0;
        end else begin
            act_q    <= active;
            byte_evt <= 1'b0;
            if (active && !act_q) begin
                armed_q   <= arm;
                byte_addr <= addr;
            end
            if (!active && act_q && armed_q) begin
                byte_evt  <= 1'b1;
                byte_data <= din;
            end
        end
    end

    // R4: a byte event is reported only after the strobe has closed
    a_r4_evt_after_close: assert property (@(posedge clk) disable iff (rst)
        byte_evt |-> !active);
    // R2: one event per strobe, never on consecutive cycles
    a_r2_evt_single: assert property (@(posedge clk) disable iff (rst)
        byte_evt |=> !byte_evt);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DW = 8,
    parameter int PW = 5,
    localparam int NB = 1 << PW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [PW-1:0]          off,
    input  logic [DW-1:0]          data,
    input  logic                   clr,
    output logic [NB-1:0][DW-1:0]  bytes,
    output logic [NB-1:0]          valid
);
    for (genvar g = 0; g < NB; g++) begin : g_slot
        logic [DW-1:0] slot_d;
        logic          slot_v;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                slot_v <= 1'b0;
                slot_d <= '1;
            end else if (wr && off == PW'(g)) begin
                slot_v <= 1'b1;
                slot_d <= data;
            end
        end
        assign bytes[g] = slot_d;
        assign valid[g] = slot_v;
    end

    // R10: the newest write to a slot is what the slot holds
    a_r10_last_wins: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> (bytes[$past(off)] == $past(data)) && valid[$past(off)]);
endmodule

// File: rtl/eep_load_seq.sv
module eep_load_seq
    import eep_pkg::*;
#(
    parameter int AW          = 11,
    parameter int PW          = 5,
    parameter int LOAD_WIN    = 3000,
    parameter int PROG_CYC    = 500000,
    parameter int POWERUP_CYC = 1000000,
    localparam int GW = AW - PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_evt,
    input  logic [AW-1:0] byte_addr,
    input  logic          strobe_act,
    output seq_state_t    state,
    output logic          arm,
    output logic          accept,
    output logic          commit,
    output logic [GW-1:0] page_q
);
    localparam int CW = cnt_width(LOAD_WIN, PROG_CYC, POWERUP_CYC);
    localparam logic [CW-1:0] LW_LAST = CW'(LOAD_WIN - 1);
    localparam logic [CW-1:0] PC_LAST = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] PU_LAST = CW'(POWERUP_CYC - 1);

    logic [CW-1:0] cnt;
    logic          page_hit;

    always_comb begin
        page_hit = byte_addr[AW-1:PW] == page_q;
        arm      = (state == ST_IDLE) || (state == ST_LOAD);
        accept   = byte_evt && ((state == ST_IDLE) ||
                                ((state == ST_LOAD) && page_hit));
        commit   = (state == ST_PROG) && (cnt == PC_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_INHIBIT;
            cnt    <= '0;
            page_q <= '0;
        end else begin
            unique case (state)
                ST_INHIBIT: begin
                    if (cnt == PU_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        page_q <= byte_addr[AW-1:PW];
                        state  <= ST_LOAD;
                        cnt    <= '0;
                    end
                end
                ST_LOAD: begin
                    if (strobe_act || byte_evt) begin
                        cnt <= '0;
                    end else if (cnt == LW_LAST) begin
                        state <= ST_PROG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (commit) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: no byte event can arrive while programming or inhibited
    a_r9_no_evt_in_prog: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROG || state == ST_INHIBIT) |-> !byte_evt);
    // R7: committing returns the sequencer to idle
    a_r7_commit_idle: assert property (@(posedge clk) disable iff (rst)
        commit |=> state == ST_IDLE);
    // R6: the first accepted byte opens a load window
    a_r6_open_window: assert property (@(posedge clk) disable iff (rst)
        (accept && state == ST_IDLE) |=> state == ST_LOAD);
    // R5: the page of an open load never changes
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && $past(state == ST_LOAD)) |-> $stable(page_q));
    // R11: leaving the power-up interval goes only to idle
    a_r11_inhibit_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INHIBIT) |=> (state == ST_INHIBIT || state == ST_IDLE));
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 5,
    parameter int LOAD_WIN    = 3000,
    parameter int PROG_CYC    = 500000,
    parameter int POWERUP_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              rb_pull,
    output logic              load_active,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = 1 << PAGE_W;
    localparam int GW    = ADDR_W - PAGE_W;

    pins_t               pins_raw, pins_s;
    logic                strobe_act, byte_evt, arm, accept, commit;
    logic [ADDR_W-1:0]   byte_addr;
    logic [DATA_W-1:0]   byte_data;
    logic [GW-1:0]       page_q;
    seq_state_t          state;
    logic [NB-1:0][DATA_W-1:0] pbytes;
    logic [NB-1:0]       pvalid;
    logic [DATA_W-1:0]   mem [DEPTH];

    assign pins_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

    eep_pin_sync #(.W($bits(pins_t)), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    eep_strobe_det #(.AW(ADDR_W), .DW(DATA_W)) u_det (
        .clk(clk), .rst(rst), .pins(pins_s), .arm(arm),
        .addr(addr), .din(din), .active(strobe_act),
        .byte_evt(byte_evt), .byte_addr(byte_addr), .byte_data(byte_data)
    );

    eep_load_seq #(
        .AW(ADDR_W), .PW(PAGE_W), .LOAD_WIN(LOAD_WIN),
        .PROG_CYC(PROG_CYC), .POWERUP_CYC(POWERUP_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .byte_evt(byte_evt), .byte_addr(byte_addr),
        .strobe_act(strobe_act), .state(state), .arm(arm),
        .accept(accept), .commit(commit), .page_q(page_q)
    );

    eep_page_buf #(.DW(DATA_W), .PW(PAGE_W)) u_buf (
        .clk(clk), .rst(rst), .wr(accept), .off(byte_addr[PAGE_W-1:0]),
        .data(byte_data), .clr(commit), .bytes(pbytes), .valid(pvalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int i = 0; i < NB; i++) begin
                if (pvalid[i]) mem[{page_q, PAGE_W'(i)}] <= pbytes[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '1;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
            if (accept) begin
                last_addr <= byte_addr;
                last_data <= byte_data;
            end
        end
    end

    assign load_active = (state == ST_LOAD);
    assign busy        = (state == ST_LOAD) || (state == ST_PROG);
    assign rb_pull     = busy;

    // R8: an open load window always reports busy
    a_r8_load_busy: assert property (@(posedge clk) disable iff (rst)
        load_active |-> rb_pull);
    // R12: the last-byte outputs follow each accepted byte
    a_r12_last_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> (last_addr == $past(byte_addr)) && (last_data == $past(byte_data)));
    // R11: nothing is busy during the power-up interval
    a_r11_quiet_inhibit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INHIBIT) |-> !busy);
endmodule

// File: tb/sim_eep_page_writer.sv
module sim_eep_page_writer;
    localparam int LW = 40;
    localparam int PC = 60;
    localparam int PU = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0, rd_addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  rd_data, last_data;
    logic [10:0] last_addr;
    logic        busy, rb_pull, load_active;

    int nchk = 0, nfail = 0;
    logic [7:0]  exp_mem [2048];
    logic [7:0]  pend_d [32];
    logic        pend_v [32];
    logic        pend_any;
    logic [5:0]  pend_page;
    logic [10:0] exp_la;
    logic [7:0]  exp_ld;

    always #5 clk = ~clk;

    eep_page_writer #(
        .ADDR_W(11), .DATA_W(8), .PAGE_W(5),
        .LOAD_WIN(LW), .PROG_CYC(PC), .POWERUP_CYC(PU)
    ) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .rb_pull(rb_pull), .load_active(load_active),
        .last_addr(last_addr), .last_data(last_data)
    );

    task automatic chk(string tag, int act, int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wcyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 0: write enable opens and closes the strobe; mode 1: chip enable does
    task automatic strobe(logic [10:0] a, logic [7:0] d, int mode, logic oe);
        oe_n = oe;
        din  = d;
        addr = ~a;
        if (mode == 0) ce_n = 1'b0; else we_n = 1'b0;
        wcyc(2);
        addr = a;
        if (mode == 0) we_n = 1'b0; else ce_n = 1'b0;
        wcyc(5);
        addr = ~a;
        if (mode == 0) we_n = 1'b1; else ce_n = 1'b1;
        wcyc(5);
        din = ~d;
        if (mode == 0) ce_n = 1'b1; else we_n = 1'b1;
        wcyc(3);
        oe_n = 1'b1;
    endtask

    function automatic logic model_accept(logic [10:0] a);
        return !pend_any || (a[10:5] == pend_page);
    endfunction

    task automatic put_byte(logic [10:0] a, logic [7:0] d, int mode);
        if (model_accept(a)) begin
            pend_any = 1'b1;
            pend_page = a[10:5];
            pend_v[a[4:0]] = 1'b1;
            pend_d[a[4:0]] = d;
            exp_la = a;
            exp_ld = d;
        end
        strobe(a, d, mode, 1'b1);
    endtask

    task automatic model_commit();
        for (int i = 0; i < 32; i++) begin
            if (pend_v[i]) exp_mem[{pend_page, 5'(i)}] = pend_d[i];
            pend_v[i] = 1'b0;
        end
        pend_any = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        int n = 0;
        while (busy && n < 1000) begin wcyc(1); n++; end
        chk(tag, int'(busy), 0);
    endtask

    task automatic rd(logic [10:0] a, output logic [7:0] v);
        rd_addr = a;
        wcyc(1);
        v = rd_data;
    endtask

    task automatic chk_page(string tag, logic [5:0] pg);
        logic [7:0] v;
        for (int i = 0; i < 32; i++) begin
            rd({pg, 5'(i)}, v);
            chk(tag, v, exp_mem[{pg, 5'(i)}]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [10:0] a;
        int unsigned sd;
        sd = $urandom(32'd1207);
        for (int i = 0; i < 2048; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < 32; i++) begin pend_v[i] = 1'b0; pend_d[i] = 8'h00; end
        pend_any = 1'b0; pend_page = '0; exp_la = '0; exp_ld = '0;

        wcyc(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rb_pull", rb_pull, 0);
        chk("R1 load_active", load_active, 0);
        rd(11'd0, v);    chk("R1 cell 0", v, 8'hFF);
        rd(11'd2047, v); chk("R1 cell 2047", v, 8'hFF);

        // R11 strobe inside the power-up interval
        strobe(11'd5, 8'h12, 0, 1'b1);
        wcyc(3);
        chk("R11 busy during inhibit", busy, 0);
        wcyc(PU);
        rd(11'd5, v); chk("R11 inhibited write", v, 8'hFF);
        chk("R11 busy after inhibit", busy, 0);

        // R2 enables low with output enable also low
        strobe(11'd6, 8'h34, 0, 1'b0);
        wcyc(3);
        chk("R2 oe low busy", busy, 0);
        chk("R2 oe low load", load_active, 0);

        // Directed page load: R3 R4 R5 R8 R10 R12 R6 R9 R7
        a = {6'h03, 5'd4};
        put_byte(a, 8'hA5, 0);
        chk("R8 busy after first byte", busy, 1);
        chk("R8 rb_pull after first byte", rb_pull, 1);
        chk("R12 last_addr", last_addr, exp_la);
        chk("R12 last_data", last_data, exp_ld);
        put_byte(a + 11'd1, 8'h5A, 1);
        chk("R3 last_addr ce-controlled", last_addr, a + 11'd1);
        chk("R4 last_data ce-controlled", last_data, 8'h5A);
        put_byte({6'h09, 5'd4}, 8'h77, 0);
        chk("R5 off-page keeps last_addr", last_addr, a + 11'd1);
        chk("R12 off-page keeps last_data", last_data, 8'h5A);
        put_byte(a, 8'hC3, 1);
        wcyc(LW - 10);
        chk("R6 window still open", load_active, 1);
        wcyc(20);
        chk("R6 window expired", load_active, 0);
        chk("R8 busy during programming", busy, 1);
        strobe(a + 11'd2, 8'h11, 0, 1'b1);
        wcyc(PC - 35);
        chk("R7 still programming", busy, 1);
        wcyc(25);
        chk("R7 programming done", busy, 0);
        chk("R8 rb_pull released", rb_pull, 0);
        model_commit();
        rd(a, v);          chk("R10 later data wins", v, 8'hC3);
        rd(a + 11'd1, v);  chk("R4 data at first rise", v, 8'h5A);
        rd(a + 11'd2, v);  chk("R9 prog-time strobe ignored", v, 8'hFF);
        rd({6'h09, 5'd4}, v); chk("R5 off-page byte dropped", v, 8'hFF);
        rd(a + 11'd3, v);  chk("R13 untouched cell", v, 8'hFF);
        wcyc(LW + 10);
        chk("R9 no late load", busy, 0);

        // R7 partial reload of the same page keeps other bytes
        put_byte(a + 11'd3, 8'h3C, 0);
        wait_idle("R7 reload idle");
        model_commit();
        chk_page("R7 partial page", 6'h03);

        // R5 full 32-byte page
        for (int i = 0; i < 32; i++)
            put_byte({6'h07, 5'(i)}, 8'(i) ^ 8'h5C, i % 2);
        wait_idle("R5 full page idle");
        model_commit();
        chk_page("R5 full page", 6'h07);

        // Random loads over a few overlapping pages
        for (int it = 0; it < 8; it++) begin
            logic [5:0] pg;
            int nb;
            pg = 6'($urandom_range(0, 3));
            nb = $urandom_range(1, 8);
            for (int k = 0; k < nb; k++) begin
                logic [10:0] ra;
                ra = {pg, 5'($urandom_range(0, 31))};
                if ($urandom_range(0, 5) == 0) ra[10:5] = pg + 6'd1;
                put_byte(ra, 8'($urandom), $urandom_range(0, 1));
            end
            chk("R12 random last_addr", last_addr, exp_la);
            chk("R12 random last_data", last_data, exp_ld);
            wait_idle("R6 random idle");
            model_commit();
            chk_page("R10 random page", pg);
            chk_page("R5 random neighbour", pg + 6'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule